// File: doc/BRIEF.md
# Sleep and Wake-Up Controller

This block sits next to a processor core and decides when the core's clock is stopped for a low-power sleep and when it is started again. The core raises a one-cycle sleep request when it executes its sleep instruction. The controller accepts the request only if no enabled interrupt source is already pending. When it accepts, it stops the core clock, tells the watchdog to clear (the watchdog keeps counting), and updates two status bits: the power-down bit is cleared and the time-out bit is set. If a source is pending, the request is dropped and nothing changes.

While asleep, the block waits for one of two events. The first is a source whose flag and enable are both high; this wakes the core whatever the global interrupt enable says. The second is a watchdog time-out, which wakes the core and clears the time-out bit. On wake-up the clock enable returns and a one-cycle wake strobe is issued. If the wake-up came from an interrupt while the global enable was high, the block reports a branch to the interrupt vector once the core retires the instruction after the sleep instruction. The external reset is asynchronous and does not count as a wake-up. It puts the block back in the awake state with both status bits set.

Top module: `sleep_wake_ctrl`

## Requirements
- R1: During and after reset, `clk_en_o` is 1, `wdt_clr_o`, `wake_o` and `vector_o` are 0, and `status_o` is 8'h0C: the power-down bit is bit 2 and the time-out bit is bit 3, and all other bits always read 0. Release of `rst_ni` takes effect on the third rising clock edge, through a two-flop synchronizer.
- R2: A sleep request can be accepted while awake with no source pending. One cycle later `clk_en_o` is 0 and `wdt_clr_o` is high for exactly one cycle. The status reads power-down 0 and time-out 1.
- R3: A sleep request made while any source is pending is a no-op. `clk_en_o` stays 1, no watchdog clear is issued, and both status bits keep their values, so a set power-down bit stays set.
- R4: A source counts as pending only when its flag and its enable bit with the same index are both 1. A flag without its enable neither blocks a sleep request nor wakes the block.
- R5: While asleep, a pending source sampled at a clock edge makes `wake_o` a one-cycle pulse after that edge. `clk_en_o` returns to 1 in the same cycle. This happens whatever the value of `gie_i`, and the status bits do not change.
- R6: A source that becomes pending in the cycle right after an accepted request does not cancel the sleep. The sleep entry completes, with the watchdog clear and status update, and the wake-up follows on the next edge.
- R7: After an interrupt wake-up with `gie_i` high at the wake edge, `vector_o` pulses for one cycle, one cycle after the first `insn_done_i` that follows the wake. After a wake-up with `gie_i` low it never pulses.
- R8: While asleep, `wdt_timeout_i` wakes the block and clears the time-out bit in the same cycle as the wake strobe. A watchdog-only wake never causes a vector.
- R9: `wdt_timeout_i` while awake has no effect on any output or status bit.
- R10: Asserting `rst_ni` while asleep at once forces `clk_en_o` to 1 and `status_o` to 8'h0C, without any `wake_o` pulse.
- R11: `sleep_req_i` while asleep is ignored, and `insn_done_i` is ignored when no vector is armed.
- R12: Any of the `NUM_SRC` sources, including index 0 and index `NUM_SRC-1`, can wake the block.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Free-running controller clock |
| rst_ni | input | 1 | External reset, active low, asynchronous assert |
| sleep_req_i | input | 1 | One-cycle strobe from the core's sleep instruction |
| irq_flag_i | input | NUM_SRC | Per-source interrupt flags |
| irq_en_i | input | NUM_SRC | Per-source interrupt enables |
| gie_i | input | 1 | Global interrupt enable |
| wdt_timeout_i | input | 1 | Watchdog time-out pulse |
| insn_done_i | input | 1 | Core retired an instruction |
| clk_en_o | output | 1 | Core clock-gate enable |
| wdt_clr_o | output | 1 | Watchdog clear strobe |
| wake_o | output | 1 | One-cycle wake strobe |
| vector_o | output | 1 | Branch to the interrupt vector now |
| status_o | output | 8 | Status: bit 2 power-down, bit 3 time-out |

## Verification
Some properties are checked on every cycle:
- Each sleep entry carries a watchdog clear and the matching status bits.
- The power-down bit stays low while the clock is gated.
- Wake, watchdog-clear and vector strobes are single pulses.
- Wake-up follows any enabled pending source or watchdog time-out while asleep.
- A sleep request made with a source pending leaves the clock running.

Other behaviours only show up in the bench's scenarios, where a cycle-by-cycle model runs alongside the block:
- The arming of the vector by the global enable, which depends on when the next instruction retires.
- The race where a source becomes pending one cycle after the request.
- The asynchronous effect of the external reset while asleep.

// File: rtl/swc_pkg.sv
package swc_pkg;
  typedef enum logic {
    ST_AWAKE  = 1'b0,
    ST_ASLEEP = 1'b1
  } pwr_state_e;

  localparam int unsigned STAT_W = 8;
  localparam int unsigned PD_POS = 2;
  localparam int unsigned TO_POS = 3;
endpackage

// File: rtl/swc_rst_sync.sv
module swc_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_no = sync_q[STAGES-1];
endmodule

// File: rtl/swc_pend_detect.sv
module swc_pend_detect #(
  parameter int unsigned NUM_SRC = 11
) (
  input  logic [NUM_SRC-1:0] flag_i,
  input  logic [NUM_SRC-1:0] en_i,
  output logic               any_pend_o
);
  logic [NUM_SRC-1:0] live;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    assign live[g] = flag_i[g] & en_i[g];
  end

  assign any_pend_o = |live;
endmodule

// File: rtl/swc_fsm.sv
module swc_fsm
  import swc_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sleep_req_i,
  input  logic any_pend_i,
  input  logic wdt_timeout_i,
  output logic clk_en_o,
  output logic wdt_clr_o,
  output logic wake_o,
  output logic pd_o,
  output logic to_o,
  output logic enter_o,
  output logic irq_wake_o
);
  pwr_state_e state_q;
  logic       enter, leave;

  assign enter      = (state_q == ST_AWAKE) && sleep_req_i && !any_pend_i;
  assign leave      = (state_q == ST_ASLEEP) && (any_pend_i || wdt_timeout_i);
  assign enter_o    = enter;
  assign irq_wake_o = (state_q == ST_ASLEEP) && any_pend_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_AWAKE;
      clk_en_o  <= 1'b1;
      wdt_clr_o <= 1'b0;
      wake_o    <= 1'b0;
      pd_o      <= 1'b1;
      to_o      <= 1'b1;
    end else begin
      wdt_clr_o <= enter;
      wake_o    <= leave;
      if (enter) begin
        state_q  <= ST_ASLEEP;
        clk_en_o <= 1'b0;
        pd_o     <= 1'b0;
        to_o     <= 1'b1;
      end else if (leave) begin
        state_q  <= ST_AWAKE;
        clk_en_o <= 1'b1;
        if (wdt_timeout_i) to_o <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/swc_vector.sv
module swc_vector (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic enter_i,
  input  logic irq_wake_i,
  input  logic gie_i,
  input  logic insn_done_i,
  output logic vector_o
);
  logic armed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q  <= 1'b0;
      vector_o <= 1'b0;
    end else begin
      vector_o <= 1'b0;
      if (enter_i) begin
        armed_q <= 1'b0;
      end else if (irq_wake_i && gie_i) begin
        armed_q <= 1'b1;
      end else if (armed_q && insn_done_i) begin
        armed_q  <= 1'b0;
        vector_o <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/sleep_wake_ctrl.sv
module sleep_wake_ctrl
  import swc_pkg::*;
#(
  parameter int unsigned NUM_SRC = 11
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               sleep_req_i,
  input  logic [NUM_SRC-1:0] irq_flag_i,
  input  logic [NUM_SRC-1:0] irq_en_i,
  input  logic               gie_i,
  input  logic               wdt_timeout_i,
  input  logic               insn_done_i,
  output logic               clk_en_o,
  output logic               wdt_clr_o,
  output logic               wake_o,
  output logic               vector_o,
  output logic [STAT_W-1:0]  status_o
);
  logic rst_sync_n;
  logic any_pend;
  logic pd, to, enter, irq_wake;

  swc_rst_sync #(.STAGES(2)) u_rst (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rst_sync_no (rst_sync_n)
  );

  swc_pend_detect #(.NUM_SRC(NUM_SRC)) u_pend (
    .flag_i     (irq_flag_i),
    .en_i       (irq_en_i),
    .any_pend_o (any_pend)
  );

  swc_fsm u_fsm (
    .clk_i         (clk_i),
    .rst_ni        (rst_sync_n),
    .sleep_req_i   (sleep_req_i),
    .any_pend_i    (any_pend),
    .wdt_timeout_i (wdt_timeout_i),
    .clk_en_o      (clk_en_o),
    .wdt_clr_o     (wdt_clr_o),
    .wake_o        (wake_o),
    .pd_o          (pd),
    .to_o          (to),
    .enter_o       (enter),
    .irq_wake_o    (irq_wake)
  );

  swc_vector u_vec (
    .clk_i       (clk_i),
    .rst_ni      (rst_sync_n),
    .enter_i     (enter),
    .irq_wake_i  (irq_wake),
    .gie_i       (gie_i),
    .insn_done_i (insn_done_i),
    .vector_o    (vector_o)
  );

  always_comb begin
    status_o         = '0;
    status_o[PD_POS] = pd;
    status_o[TO_POS] = to;
  end
endmodule

// File: rtl/swc_checker.sv
module swc_checker #(
  parameter int unsigned NUM_SRC = 11
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               sleep_req_i,
  input logic [NUM_SRC-1:0] irq_flag_i,
  input logic [NUM_SRC-1:0] irq_en_i,
  input logic               wdt_timeout_i,
  input logic               clk_en_o,
  input logic               wdt_clr_o,
  input logic               wake_o,
  input logic               vector_o,
  input logic [7:0]         status_o
);
  logic pend;
  assign pend = |(irq_flag_i & irq_en_i);

  AST_STATUS_SPARE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o & 8'hF3) == 8'h00); // R1
  AST_ENTRY_CLEARS_WDT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(clk_en_o) |-> wdt_clr_o && !status_o[2] && status_o[3]); // R2
  AST_PD_LOW_ASLEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clk_en_o |-> !status_o[2]); // R2
  AST_WDT_CLR_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wdt_clr_o |=> !wdt_clr_o); // R2
  AST_NOOP_KEEPS_CLK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clk_en_o && sleep_req_i && pend) |=> clk_en_o && !wdt_clr_o); // R3
  AST_IRQ_WAKES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clk_en_o && pend) |=> wake_o && clk_en_o); // R5
  AST_WAKE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_o |=> !wake_o); // R5
  AST_WAKE_CLK_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_o |-> clk_en_o && !$past(clk_en_o)); // R5
  AST_VEC_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vector_o |=> !vector_o); // R7
  AST_VEC_AWAKE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vector_o |-> clk_en_o); // R7
  AST_WDT_WAKES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clk_en_o && wdt_timeout_i) |=> wake_o && !status_o[3]); // R8
endmodule

bind sleep_wake_ctrl swc_checker #(.NUM_SRC(NUM_SRC)) chk_i (
  .clk_i         (clk_i),
  .rst_ni        (rst_sync_n),
  .sleep_req_i   (sleep_req_i),
  .irq_flag_i    (irq_flag_i),
  .irq_en_i      (irq_en_i),
  .wdt_timeout_i (wdt_timeout_i),
  .clk_en_o      (clk_en_o),
  .wdt_clr_o     (wdt_clr_o),
  .wake_o        (wake_o),
  .vector_o      (vector_o),
  .status_o      (status_o)
);

// File: tb/sleep_wake_ctrl_tb_top.sv
module sleep_wake_ctrl_tb_top;
  localparam int NS = 11;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          sleep_req = 1'b0;
  logic [NS-1:0] flag = '0;
  logic [NS-1:0] en = '0;
  logic          gie = 1'b0;
  logic          wdt = 1'b0;
  logic          done = 1'b0;
  logic          clk_en, wdt_clr, wake, vec;
  logic [7:0]    status;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  always #5 clk = ~clk;

  sleep_wake_ctrl #(.NUM_SRC(NS)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .sleep_req_i(sleep_req),
    .irq_flag_i(flag), .irq_en_i(en), .gie_i(gie),
    .wdt_timeout_i(wdt), .insn_done_i(done),
    .clk_en_o(clk_en), .wdt_clr_o(wdt_clr), .wake_o(wake),
    .vector_o(vec), .status_o(status)
  );

  // behavioural reference model
  int m_rcnt = 0;
  bit m_asleep = 0, m_armed = 0;
  bit m_clk = 1, m_wclr = 0, m_wake = 0, m_vec = 0, m_pd = 1, m_to = 1;

  task automatic m_reset();
    m_asleep = 0; m_armed = 0; m_clk = 1; m_wclr = 0;
    m_wake = 0; m_vec = 0; m_pd = 1; m_to = 1;
  endtask

  always @(negedge rst_n) begin
    m_rcnt = 0;
    m_reset();
  end

  always @(posedge clk) begin
    bit pend;
    pend = 0;
    for (int i = 0; i < NS; i++) if (flag[i] && en[i]) pend = 1;
    if (!rst_n || m_rcnt < 2) begin
      m_reset();
      if (rst_n) m_rcnt++;
    end else begin
      m_wclr = 0; m_wake = 0; m_vec = 0;
      if (!m_asleep) begin
        if (sleep_req && !pend) begin
          m_asleep = 1; m_clk = 0; m_wclr = 1; m_pd = 0; m_to = 1; m_armed = 0;
        end else if (m_armed && done) begin
          m_armed = 0; m_vec = 1;
        end
      end else if (pend || wdt) begin
        m_asleep = 0; m_clk = 1; m_wake = 1;
        if (wdt) m_to = 0;
        if (pend && gie) m_armed = 1;
      end
    end
  end

  task automatic chk(string tag, int got, int exp);
    n_chk++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h at %0t", tag, got, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    chk("R1 model clk_en_o", clk_en, m_clk);
    chk("R2 model wdt_clr_o", wdt_clr, m_wclr);
    chk("R5 model wake_o", wake, m_wake);
    chk("R7 model vector_o", vec, m_vec);
    chk("R8 model status_o", status, {4'h0, m_to, m_pd, 2'b00});
  end

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      n_fail++;
      $display("FAIL watchdog: got %0d cycles expected fewer than 20000", cyc);
      finish_run();
    end
  end

  task automatic tick(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic go_sleep();
    sleep_req = 1; tick(); sleep_req = 0;
  endtask

  initial begin
    tick(3);
    chk("R1 clk_en in reset", clk_en, 1);
    chk("R1 status in reset", status, 8'h0C);
    rst_n = 1;
    tick(3);
    chk("R1 clk_en after reset", clk_en, 1);
    chk("R1 status after reset", status, 8'h0C);
    chk("R1 wake after reset", wake, 0);

    // R3: pending source turns the request into a no-op
    flag[3] = 1; en[3] = 1;
    go_sleep();
    chk("R3 clk stays on", clk_en, 1);
    chk("R3 no wdt clear", wdt_clr, 0);
    chk("R3 pd stays set", status, 8'h0C);
    flag = '0; en = '0; tick();

    // R2 accept, R5 wake with gie low
    go_sleep();
    chk("R2 clk off", clk_en, 0);
    chk("R2 wdt clear", wdt_clr, 1);
    chk("R2 status", status, 8'h08);
    tick();
    chk("R2 wdt clear pulse", wdt_clr, 0);
    tick(3);
    chk("R5 still asleep", clk_en, 0);
    flag[0] = 1; en[0] = 1; gie = 0;
    tick();
    chk("R5 wake pulse", wake, 1);
    chk("R5 clk on with wake", clk_en, 1);
    chk("R12 source 0 wakes", wake, 1);
    chk("R5 status kept", status, 8'h08);
    flag = '0; en = '0;
    tick();
    chk("R5 wake single", wake, 0);
    done = 1; tick(); done = 0; tick();
    chk("R7 no vector with gie low", vec, 0);

    // R4 flag without enable, R12 top source
    flag[NS-1] = 1; en[0] = 1;
    go_sleep();
    chk("R4 unenabled flag does not block", clk_en, 0);
    tick(3);
    chk("R4 unenabled flag does not wake", clk_en, 0);
    en[NS-1] = 1;
    tick();
    chk("R12 top source wakes", wake, 1);
    flag = '0; en = '0; tick();

    // R7 vector with gie high
    go_sleep(); tick(2);
    flag[5] = 1; en[5] = 1; gie = 1;
    tick();
    chk("R7 wake", wake, 1);
    flag = '0; en = '0; gie = 0;
    tick(2);
    chk("R7 no vector before done", vec, 0);
    done = 1; tick(); done = 0;
    chk("R7 vector pulse", vec, 1);
    tick();
    chk("R7 vector single", vec, 0);
    done = 1; tick(); done = 0; tick();
    chk("R11 done ignored when unarmed", vec, 0);

    // R6 pending right after accept
    sleep_req = 1; tick(); sleep_req = 0;
    flag[2] = 1; en[2] = 1;
    chk("R6 sleep completed", clk_en, 0);
    chk("R6 wdt cleared", wdt_clr, 1);
    tick();
    chk("R6 immediate wake", wake, 1);
    flag = '0; en = '0; tick();

    // R8 watchdog wake, R9 watchdog while awake
    go_sleep(); tick();
    wdt = 1; tick(); wdt = 0;
    chk("R8 wdt wakes", wake, 1);
    chk("R8 to cleared", status, 8'h00);
    done = 1; tick(); done = 0; tick();
    chk("R8 no vector", vec, 0);
    wdt = 1; tick(); wdt = 0;
    chk("R9 clk unchanged", clk_en, 1);
    chk("R9 no wake", wake, 0);
    chk("R9 status unchanged", status, 8'h00);

    // R11 request while asleep
    go_sleep();
    sleep_req = 1; tick(); sleep_req = 0;
    chk("R11 no second clear", wdt_clr, 0);
    chk("R11 still asleep", clk_en, 0);

    // R10 external reset while asleep
    #2 rst_n = 0;
    #1;
    chk("R10 clk forced on", clk_en, 1);
    chk("R10 status reset", status, 8'h0C);
    chk("R10 no wake", wake, 0);
    tick(2);
    rst_n = 1;
    tick(3);
    chk("R10 awake after release", clk_en, 1);
    tick(2);
    finish_run();
  end
endmodule